// File: doc/BRIEF.md
# Command-Triggered Byte-Stream Transfer Engine

This block moves data between a software-visible 32-bit data window and a card-side byte stream through a byte FIFO. Software writes one command word. That single write decodes a transfer code, a byte length and a buffer-select flag, and it launches the transfer at once. No separate start bit is needed. A direction input is captured with the command and decides which side fills the FIFO and which side drains it. In host-to-card transfers, software packs words into the FIFO and the card side pulls bytes out. In card-to-host transfers, the card side pushes bytes in and software reads them back as words. The window is big-endian: the most significant byte of a word is the first byte in stream order.

The engine counts card-side bytes. When the count reaches the programmed length, the engine raises a one-cycle completion strobe. At that moment it checks whether the bytes left in the FIFO agree with the length and records a sticky mismatch flag if they do not. A sticky underrun flag records any software read of an empty FIFO. A soft reset input returns everything to idle in a single cycle. When the buffer select is clear, the card side may fill only a small slice of the storage.

Top module: `xfer_fifo_engine`

## Requirements
- R1: A write on `cmd_we` while idle captures the transfer code from bits 31:28, the length from bits 25:16 and the buffer select from bit 26, together with `dir_h2c`. These appear on `xfer_code` and `big_sel` from the next cycle. `busy` rises in that cycle when the length is non-zero.
- R2: A command with length zero raises `done` for exactly one cycle, in the cycle after the write. `busy` stays low, and `mismatch` is not set.
- R3: A command written while `busy` is high is ignored. The code, length and select of the running transfer are kept, and that transfer finishes at its own length.
- R4: Host-to-card (`dir_h2c`=1): each window write adds four bytes. Bits 31:24 are presented first on `card_tx_data`, then 23:16, 15:8 and 7:0. A byte moves on a cycle where `card_tx_valid` and `card_tx_ready` are both high.
- R5: Card-to-host (`dir_h2c`=0): bytes accepted while `card_rx_valid` and `card_rx_ready` are both high are read back through the window, the oldest byte in bits 31:24. A read removes min(4, held) bytes. Byte lanes with no data read as zero. `win_rdata` updates in the cycle after the read.
- R6: `done` pulses for one cycle, in the cycle after the card-side byte that brings the count to the length. `busy` is low in that cycle.
- R7: At completion, `mismatch` becomes set (sticky) if the FIFO still holds bytes in host-to-card mode, or holds a byte count other than the length in card-to-host mode.
- R8: A window read while the FIFO is empty returns zero and sets the sticky `underrun` flag.
- R9: `fifo_empty` is high exactly when the FIFO holds no bytes. It is high after reset.
- R10: With buffer select clear, `card_rx_ready` stays low while 32 or more bytes are held. Accepting resumes after software drains data.
- R11: `soft_rst` empties the FIFO, clears `underrun` and `mismatch`, and makes the engine idle by the next cycle.
- R12: While a transfer runs, window accesses in the card's own direction are ignored. In host-to-card, reads return zero, remove nothing and leave `underrun` alone. In card-to-host, writes add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset to idle |
| cmd_we | input | 1 | Command write strobe; starts a transfer |
| cmd_wdata | input | 32 | Command word: code, select, length |
| dir_h2c | input | 1 | Direction, captured with command: 1 host-to-card, 0 card-to-host |
| win_we | input | 1 | Data window write strobe |
| win_wdata | input | 32 | Data window write word (big-endian) |
| win_re | input | 1 | Data window read strobe |
| win_rdata | output | 32 | Data window read word, valid the cycle after the read |
| card_tx_valid | output | 1 | Outgoing byte available to the card |
| card_tx_data | output | 8 | Outgoing byte |
| card_tx_ready | input | 1 | Card takes the outgoing byte |
| card_rx_valid | input | 1 | Card offers an incoming byte |
| card_rx_data | input | 8 | Incoming byte |
| card_rx_ready | output | 1 | Engine accepts the incoming byte |
| busy | output | 1 | Transfer in progress |
| xfer_code | output | 4 | Captured transfer code |
| big_sel | output | 1 | Captured buffer select |
| fifo_empty | output | 1 | FIFO holds no bytes |
| underrun | output | 1 | Sticky: empty FIFO was read |
| mismatch | output | 1 | Sticky: bytes held at completion disagree with length |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of faulty design:

- Transfers whose length is not a multiple of four, in both directions. A design that rounds to words would send or accept extra bytes, or would pad the wrong byte lanes of the last read.
- Leftover host bytes and preloaded card-to-host data. A design that evaluates the agreement check against the wrong level would miss the mismatch flag.
- A zero-length command. A design that waits for data here would never raise `done`.
- A second command issued mid-transfer, and same-direction window accesses during a run. A design that ignores neither would overwrite the length, steal bytes or set `underrun`.
- The small-buffer stall at 32 bytes, and a soft reset after a sticky flag was set. These check that the small-buffer limit and the sticky flags both behave at their edges.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  // Command word layout
  localparam int CMD_LEN_LSB  = 16;
  localparam int CMD_LEN_W    = 10;
  localparam int CMD_BIG_BIT  = 26;
  localparam int CMD_CODE_LSB = 28;
  localparam int CMD_CODE_W   = 4;
  localparam int WORD_BYTES   = 4;

  typedef struct packed {
    logic [CMD_CODE_W-1:0] code;
    logic                  big;
    logic [CMD_LEN_W-1:0]  len;
  } xfer_cmd_t;

  function automatic xfer_cmd_t cmd_unpack(input logic [31:0] w);
    xfer_cmd_t c;
    c.code = w[CMD_CODE_LSB +: CMD_CODE_W];
    c.big  = w[CMD_BIG_BIT];
    c.len  = w[CMD_LEN_LSB +: CMD_LEN_W];
    return c;
  endfunction

  // Bytes one window read removes: all held, at most one word
  function automatic logic [2:0] word_pop_bytes(input logic [15:0] lvl);
    return (lvl >= 16'(WORD_BYTES)) ? 3'(WORD_BYTES) : lvl[2:0];
  endfunction

  // Keep the first n bytes (from the top lane), zero the rest
  function automatic logic [31:0] be_pack(input logic [31:0] raw, input logic [2:0] n);
    logic [31:0] w;
    for (int k = 0; k < WORD_BYTES; k++)
      w[31-8*k -: 8] = (3'(k) < n) ? raw[31-8*k -: 8] : 8'h00;
    return w;
  endfunction

  // Agreement test at completion
  function automatic logic len_mismatch(input logic h2c, input logic [15:0] lvl_after,
                                        input logic [CMD_LEN_W-1:0] len);
    return h2c ? (lvl_after != 16'd0) : (lvl_after != 16'(len));
  endfunction
endpackage

// File: rtl/xfer_byte_fifo.sv
`timescale 1ns/1ps
module xfer_byte_fifo
  import xfer_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sw_push,
  input  logic [31:0]      sw_wdata,
  input  logic             card_push,
  input  logic [7:0]       card_byte,
  input  logic             sw_pop,
  input  logic             card_pop,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_next,
  output logic [31:0]      head_word,
  output logic [7:0]       head_byte
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LVL_W-1:0] push_n, pop_n;
  logic [31:0]      raw;

  always_comb begin
    push_n = sw_push ? LVL_W'(WORD_BYTES) : (card_push ? LVL_W'(1) : '0);
    pop_n  = sw_pop  ? LVL_W'(word_pop_bytes(16'(level))) : (card_pop ? LVL_W'(1) : '0);
    level_next = level + push_n - pop_n;
  end

  always_comb begin
    for (int k = 0; k < WORD_BYTES; k++)
      raw[31-8*k -: 8] = mem[PW'(rp + PW'(k))];
  end

  assign head_word = be_pack(raw, word_pop_bytes(16'(level)));
  assign head_byte = raw[31:24];

  always_ff @(posedge clk) begin
    if (sw_push) begin
      for (int k = 0; k < WORD_BYTES; k++)
        mem[PW'(wp + PW'(k))] <= sw_wdata[31-8*k -: 8];
    end else if (card_push) begin
      mem[wp] <= card_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + PW'(push_n);
      rp    <= rp + PW'(pop_n);
      level <= level_next;
    end
  end

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_pop |-> level != '0);
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

// File: rtl/xfer_cmd_ctl.sv
`timescale 1ns/1ps
module xfer_cmd_ctl
  import xfer_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  cmd_we,
  input  logic [31:0]           cmd_wdata,
  input  logic                  dir_h2c,
  input  logic                  card_fire,
  input  logic [LVL_W-1:0]      lvl_next,
  output logic                  busy,
  output logic                  dir_q,
  output logic                  big_q,
  output logic [CMD_CODE_W-1:0] code_q,
  output logic [CMD_LEN_W-1:0]  len_q,
  output logic                  done,
  output logic                  mismatch
);
  xfer_cmd_t            cmd_in;
  logic [CMD_LEN_W-1:0] cnt;
  logic                 cmd_take, last_byte;

  assign cmd_in    = cmd_unpack(cmd_wdata);
  assign cmd_take  = cmd_we && !busy;
  assign last_byte = busy && card_fire && (CMD_LEN_W'(cnt + 1'b1) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_q <= 1'b1; big_q <= 1'b1; code_q <= '0;
      len_q <= '0; cnt <= '0; done <= 1'b0; mismatch <= 1'b0;
    end else if (soft_rst) begin
      busy <= 1'b0; dir_q <= 1'b1; big_q <= 1'b1; code_q <= '0;
      len_q <= '0; cnt <= '0; done <= 1'b0; mismatch <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_take) begin
        code_q <= cmd_in.code;
        len_q  <= cmd_in.len;
        big_q  <= cmd_in.big;
        dir_q  <= dir_h2c;
        cnt    <= '0;
        if (cmd_in.len == '0) done <= 1'b1;
        else                  busy <= 1'b1;
      end else if (busy && card_fire) begin
        cnt <= cnt + 1'b1;
        if (last_byte) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (len_mismatch(dir_q, 16'(lvl_next), len_q)) mismatch <= 1'b1;
        end
      end
    end
  end

  // R3
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    busy && cmd_we |=> $stable(len_q) && $stable(code_q) && $stable(big_q));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    cmd_we && !busy && (cmd_wdata[CMD_LEN_LSB +: CMD_LEN_W] == '0) |=> done && !busy);
endmodule

// File: rtl/xfer_fifo_engine.sv
`timescale 1ns/1ps
module xfer_fifo_engine
  import xfer_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SMALL_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        dir_h2c,
  input  logic        win_we,
  input  logic [31:0] win_wdata,
  input  logic        win_re,
  output logic [31:0] win_rdata,
  output logic        card_tx_valid,
  output logic [7:0]  card_tx_data,
  input  logic        card_tx_ready,
  input  logic        card_rx_valid,
  input  logic [7:0]  card_rx_data,
  output logic        card_rx_ready,
  output logic        busy,
  output logic [3:0]  xfer_code,
  output logic        big_sel,
  output logic        fifo_empty,
  output logic        underrun,
  output logic        mismatch,
  output logic        done
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] level, level_next, cap;
  logic [31:0]      head_word;
  logic [7:0]       head_byte;
  logic             dir_q;
  logic [CMD_LEN_W-1:0] len_q;
  // named internal events
  logic h2c_act, c2h_act;
  logic sw_push_ev, sw_pop_ev, rd_empty_ev, card_push_ev, card_pop_ev, card_fire;

  assign h2c_act      = busy && dir_q;
  assign c2h_act      = busy && !dir_q;
  assign cap          = big_sel ? LVL_W'(DEPTH) : LVL_W'(SMALL_DEPTH);
  assign sw_push_ev   = win_we && !c2h_act && ({1'b0, level} + (LVL_W+1)'(WORD_BYTES) <= (LVL_W+1)'(DEPTH));
  assign sw_pop_ev    = win_re && !h2c_act && (level != '0);
  assign rd_empty_ev  = win_re && !h2c_act && (level == '0);
  assign card_rx_ready = c2h_act && (level < cap);
  assign card_push_ev = card_rx_valid && card_rx_ready;
  assign card_tx_valid = h2c_act && (level != '0);
  assign card_tx_data = head_byte;
  assign card_pop_ev  = card_tx_valid && card_tx_ready;
  assign card_fire    = card_push_ev || card_pop_ev;
  assign fifo_empty   = (level == '0);

  xfer_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .sw_push(sw_push_ev), .sw_wdata(win_wdata),
    .card_push(card_push_ev), .card_byte(card_rx_data),
    .sw_pop(sw_pop_ev), .card_pop(card_pop_ev),
    .level(level), .level_next(level_next),
    .head_word(head_word), .head_byte(head_byte)
  );

  xfer_cmd_ctl #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .dir_h2c(dir_h2c),
    .card_fire(card_fire), .lvl_next(level_next),
    .busy(busy), .dir_q(dir_q), .big_q(big_sel), .code_q(xfer_code),
    .len_q(len_q), .done(done), .mismatch(mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_rdata <= '0;
      underrun  <= 1'b0;
    end else if (soft_rst) begin
      win_rdata <= '0;
      underrun  <= 1'b0;
    end else begin
      if (win_re) win_rdata <= sw_pop_ev ? head_word : 32'h0;
      if (rd_empty_ev) underrun <= 1'b1;
    end
  end

  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rd_empty_ev |=> underrun && (win_rdata == 32'h0));
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> fifo_empty && !busy && !underrun && !mismatch);
  // R12
  h2c_read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    h2c_act && win_re |=> $stable(underrun) && (win_rdata == 32'h0));
  // R1
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    cmd_we && !busy && (cmd_wdata[CMD_LEN_LSB +: CMD_LEN_W] != '0) |=> busy);
endmodule

// File: tb/test_xfer_fifo_engine.sv
`timescale 1ns/1ps
module test_xfer_fifo_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, soft_rst = 1'b0;
  logic        cmd_we = 1'b0, dir_h2c = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        win_we = 1'b0, win_re = 1'b0;
  logic [31:0] win_wdata = '0, win_rdata;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic [7:0]  card_tx_data;
  logic        card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0;
  logic        busy, big_sel, fifo_empty, underrun, mismatch, done;
  logic [3:0]  xfer_code;

  int nchk = 0, nfail = 0, pat_i = 0;
  logic [7:0] mq[$];

  always #2.5 clk = ~clk;

  xfer_fifo_engine i_xfer_fifo_engine (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .dir_h2c(dir_h2c),
    .win_we(win_we), .win_wdata(win_wdata), .win_re(win_re), .win_rdata(win_rdata),
    .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
    .busy(busy), .xfer_code(xfer_code), .big_sel(big_sel), .fifo_empty(fifo_empty),
    .underrun(underrun), .mismatch(mismatch), .done(done)
  );

  // {dir(1), preload words(5), length(10)}
  localparam logic [15:0] VEC [6] = '{
    {1'b1, 5'd2, 10'd8}, {1'b1, 5'd3, 10'd10}, {1'b1, 5'd1, 10'd3},
    {1'b0, 5'd0, 10'd12}, {1'b0, 5'd0, 10'd7}, {1'b0, 5'd1, 10'd5}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_soft_rst();
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    mq.delete();
  endtask

  task automatic sw_write(input logic [31:0] w, input bit model);
    win_we = 1'b1; win_wdata = w; step(); win_we = 1'b0;
    if (model) for (int k = 0; k < 4; k++) mq.push_back(w[31-8*k -: 8]);
  endtask

  task automatic sw_read(output logic [31:0] r);
    win_re = 1'b1; step(); win_re = 1'b0; r = win_rdata;
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (mq.size() != 0) w[31-8*k -: 8] = mq.pop_front();
    return w;
  endfunction

  task automatic issue(input logic [3:0] code, input logic [9:0] len, input bit big, input bit dir);
    cmd_we = 1'b1; cmd_wdata = {code, 1'b0, big, len, 16'h0}; dir_h2c = dir;
    step(); cmd_we = 1'b0;
  endtask

  task automatic run_h2c(input int maxc, output int got, output bit dn);
    got = 0; dn = 0; card_tx_ready = 1'b1;
    for (int c = 0; c < maxc && !dn; c++) begin
      #1;
      if (card_tx_valid) begin
        logic [7:0] e;
        e = (mq.size() != 0) ? mq.pop_front() : 8'hxx;
        chk(card_tx_data === e, "R4 outgoing byte order", {24'h0, card_tx_data}, {24'h0, e});
        got++;
      end
      @(posedge clk); #1;
      if (done) dn = 1;
    end
    card_tx_ready = 1'b0;
  endtask

  task automatic run_c2h(input int maxc, output int got, output bit dn);
    got = 0; dn = 0; card_rx_valid = 1'b1;
    for (int c = 0; c < maxc && !dn; c++) begin
      card_rx_data = 8'h30 + pat_i[7:0];
      #1;
      if (card_rx_ready) begin
        mq.push_back(card_rx_data); pat_i++; got++;
      end
      @(posedge clk); #1;
      if (done) dn = 1;
    end
    card_rx_valid = 1'b0;
  endtask

  task automatic drain_check(input string tag);
    logic [31:0] r, e;
    while (mq.size() != 0) begin
      e = model_word();
      sw_read(r);
      chk(r === e, tag, r, e);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int got; bit dn; logic [31:0] r, e; bit em;
    step(); step(); rst_n = 1'b1; step();

    // Reset state: R9 R11
    chk(fifo_empty === 1'b1, "R9 empty after reset", {31'h0, fifo_empty}, 32'h1);
    chk({busy, underrun, mismatch, done, card_tx_valid, card_rx_ready} === 6'b0,
        "R11 idle after reset", {26'h0, busy, underrun, mismatch, done, card_tx_valid, card_rx_ready}, 32'h0);

    // Table walk: R1 R4 R5 R6 R7
    foreach (VEC[v]) begin
      logic dir; int pre; int len;
      dir = VEC[v][15]; pre = int'(VEC[v][14:10]); len = int'(VEC[v][9:0]);
      for (int p = 0; p < pre; p++) sw_write(32'hA0B1C2D3 + 32'h01010101 * p + 32'h10 * v, 1'b1);
      issue(4'(v + 1), 10'(len), 1'b1, dir);
      chk(xfer_code === 4'(v + 1) && busy === 1'b1 && big_sel === 1'b1, "R1 command capture",
          {24'h0, xfer_code, 2'b0, big_sel, busy}, {24'h0, 4'(v + 1), 4'b0011});
      if (dir) run_h2c(2000, got, dn); else run_c2h(2000, got, dn);
      chk(dn && got == len, "R6 done after length bytes", got, len);
      chk(busy === 1'b0, "R6 idle at done", {31'h0, busy}, 32'h0);
      em = dir ? (mq.size() != 0) : (mq.size() != len);
      chk(mismatch === em, "R7 mismatch at completion", {31'h0, mismatch}, {31'h0, em});
      step();
      chk(done === 1'b0, "R6 done is one cycle", {31'h0, done}, 32'h0);
      if (!dir) drain_check("R5 card-to-host word packing");
      do_soft_rst();
    end

    // R8 underrun, R9, R11 soft reset
    sw_read(r);
    chk(r === 32'h0 && underrun === 1'b1, "R8 empty read", {r[30:0], underrun}, 32'h1);
    sw_write(32'h11223344, 1'b1);
    chk(fifo_empty === 1'b0 && underrun === 1'b1, "R9 not empty, R8 sticky", {30'h0, fifo_empty, underrun}, 32'h1);
    do_soft_rst();
    chk(fifo_empty === 1'b1 && underrun === 1'b0 && busy === 1'b0, "R11 soft reset clears",
        {29'h0, fifo_empty, underrun, busy}, 32'h4);

    // R2 zero length
    issue(4'hC, 10'd0, 1'b1, 1'b1);
    chk(done === 1'b1 && busy === 1'b0, "R2 zero length completes", {30'h0, done, busy}, 32'h2);
    step();
    chk(done === 1'b0 && mismatch === 1'b0, "R2 no mismatch, single pulse", {30'h0, done, mismatch}, 32'h0);

    // R3 command during busy, R12 read during host-to-card
    sw_write(32'hDEADBEEF, 1'b1); sw_write(32'h01020304, 1'b1);
    issue(4'h5, 10'd8, 1'b1, 1'b1);
    issue(4'h9, 10'd3, 1'b0, 1'b0);
    chk(xfer_code === 4'h5 && big_sel === 1'b1 && busy === 1'b1, "R3 second command ignored",
        {27'h0, xfer_code, big_sel}, {27'h0, 4'h5, 1'b1});
    sw_read(r);
    chk(r === 32'h0 && underrun === 1'b0, "R12 read blocked in host-to-card", {r[30:0], underrun}, 32'h0);
    run_h2c(2000, got, dn);
    chk(dn && got == 8 && mismatch === 1'b0, "R3 original length kept", got, 8);
    do_soft_rst();

    // R12 write during card-to-host
    issue(4'h3, 10'd4, 1'b1, 1'b0);
    sw_write(32'hCAFEF00D, 1'b0);
    run_c2h(2000, got, dn);
    chk(dn && mismatch === 1'b0, "R12 write blocked in card-to-host", {31'h0, mismatch}, 32'h0);
    drain_check("R12 only card bytes held");
    do_soft_rst();

    // R10 small buffer stall
    issue(4'h7, 10'd36, 1'b0, 1'b0);
    chk(big_sel === 1'b0, "R10 small select captured", {31'h0, big_sel}, 32'h0);
    run_c2h(50, got, dn);
    chk(got == 32 && !dn && card_rx_ready === 1'b0, "R10 stall at 32 bytes", got, 32);
    e = model_word(); sw_read(r);
    chk(r === e, "R5 read during card-to-host", r, e);
    run_c2h(50, got, dn);
    chk(got == 4 && dn, "R10 resumes after drain", got, 4);
    em = (mq.size() != 36);
    chk(mismatch === em, "R7 held count differs from length", {31'h0, mismatch}, {31'h0, em});
    drain_check("R5 drain after small transfer");
    sw_read(r);
    chk(r === 32'h0 && underrun === 1'b1, "R8 read past end", {r[30:0], underrun}, 32'h1);
    do_soft_rst();
    chk(mismatch === 1'b0 && underrun === 1'b0, "R11 sticky flags cleared", {30'h0, mismatch, underrun}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule